// File: doc/BRIEF.md
# Serial ADC Conversion Sequencer

This block is an SPI master that runs one complete conversion on an external 12-bit, eight-input analog-to-digital converter for each start request. When a start is accepted, it latches the requested input channel, the range selection and the polarity selection. It packs them into an 8-bit control word and pulls chip select low. The word is then shifted out in SPI mode 0, with the serial clock idling low.

Chip select stays low after the control word, and the serial clock stays idle for a fixed conversion gap of about 15 µs. The block then clocks in twelve result bits while its data output line is held low. It releases chip select, presents the result, and pulses done. The serial clock half-period and the gap length are both parameters. They are derived from the system clock frequency, a minimum clock pulse width (200 ns by default) and the gap time in nanoseconds.

The result is always presented as an unsigned 12-bit word. A flag travels with it to say whether the conversion was run in bipolar mode, in which case the word is to be read as two's complement.

Top module: `adc_conv_seq`

## Requirements
- R1: While reset is applied, and whenever no conversion is running, cs_n is 1, sclk is 0, mosi is 0, busy is 0 and done is 0.
- R2: The control word has bit 7 = 1, bits 6:4 = channel, bit 3 = range select, bit 2 = bipolar select and bits 1:0 = 0. It is sent most significant bit first, and each bit is valid on mosi at a rising sclk edge (mode 0).
- R3: Every high and every low interval of sclk inside a conversion lasts exactly HALF_CYC system clocks, where HALF_CYC = ceil(MIN_PULSE_NS × clock MHz / 1000). This is 25 at 125 MHz and 200 ns.
- R4: A conversion has exactly 20 rising sclk edges: 8 for the control word, then 12 for the result. The sclk low interval before the 9th rising edge is exactly WAIT_CYC + HALF_CYC clocks, where WAIT_CYC = ceil(GAP_NS × clock MHz / 1000). This is 1875 at 15 µs.
- R5: From the end of the control word until chip select rises, mosi is 0. The block samples miso at each of the 12 read-phase rising edges, and the first bit sampled becomes result bit 11.
- R6: cs_n falls on the cycle after a start is accepted, stays low for the whole conversion, and rises in the same cycle that done pulses.
- R7: done is a one-cycle pulse. result and result_signed change only with done and hold their values until the next done.
- R8: busy is 1 from the cycle after an accepted start, and it is 0 in the cycle that done is 1.
- R9: A start asserted while busy is 1 is ignored. It does not restart or extend the conversion, it does not change the control word being sent, and it does not queue a second conversion.
- R10: result_signed equals the bipolar select value that was latched when the conversion was started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Request one conversion; sampled only while idle |
| chan | input | 3 | Converter input channel to convert |
| range_sel | input | 1 | Range selection bit placed in the control word |
| bipolar_sel | input | 1 | Polarity selection bit placed in the control word |
| miso | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the converter |
| busy | output | 1 | A conversion is in progress |
| done | output | 1 | One-cycle pulse marking a new result |
| result | output | 12 | Last converted word, unsigned, first received bit in bit 11 |
| result_signed | output | 1 | The last result was taken in bipolar mode |

## Verification
Faults in the phase sequencer or the bit counter show up at the ports within one serial frame. A phase that ends early or late changes the count of rising sclk edges inside the chip-select window. It also moves the long low interval away from the 9th edge, so the error is visible when cs_n rises, about 2,900 clocks after start. A corrupted half-period counter changes the width of the first sclk pulse, within 50 clocks of start. A wrong shift direction or bit index shows as a wrong control word on mosi by the 8th edge, or as a wrong result word at done. A busy or idle decode that lets a second start through shows as a second chip-select window, or as a changed control word, within one frame.

// File: rtl/adcs_pkg.sv
package adcs_pkg;

  localparam int CMD_W  = 8;
  localparam int CHAN_W = 3;
  localparam int RES_W  = 12;
  localparam int SH_W   = (CMD_W > RES_W) ? CMD_W : RES_W;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_GAP  = 2'd2,
    ST_READ = 2'd3
  } seq_state_e;

  // Marker bit on top, then channel, range and polarity, two zero pad bits
  function automatic logic [CMD_W-1:0] build_ctrl(
    input logic [CHAN_W-1:0] ch,
    input logic              rng,
    input logic              bip
  );
    logic [CMD_W-1:0] w;
    w       = '0;
    w[7]    = 1'b1;
    w[6:4]  = ch;
    w[3]    = rng;
    w[2]    = bip;
    return w;
  endfunction

endpackage

// File: rtl/adcs_rst_sync.sv
module adcs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/adcs_period_cnt.sv
module adcs_period_cnt #(
  parameter int PERIOD = 25
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic en,
  output logic expire
);

  localparam int DW = $clog2(PERIOD + 1);

  logic [DW-1:0] cnt_q;
  logic [DW-1:0] cnt_d;
  logic          at_end;

  assign at_end = (cnt_q == DW'(PERIOD - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (!en) begin
      cnt_d = '0;
    end else if (at_end) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + DW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign expire = en && at_end;

endmodule

// File: rtl/adcs_shift.sv
module adcs_shift #(
  parameter int SH_W  = 12,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             load,
  input  logic [SH_W-1:0]  load_data,
  input  logic [CNT_W-1:0] load_bits,
  input  logic             tick,
  input  logic             miso,
  output logic             sclk,
  output logic             mosi,
  output logic [SH_W-1:0]  rx_word,
  output logic             last_fall
);

  logic [SH_W-1:0]  tx_q, tx_d;
  logic [SH_W-1:0]  rx_q, rx_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] bits_q, bits_d;
  logic             sclk_q, sclk_d;

  always_comb begin
    tx_d   = tx_q;
    rx_d   = rx_q;
    cnt_d  = cnt_q;
    bits_d = bits_q;
    sclk_d = sclk_q;
    if (load) begin
      tx_d   = load_data;
      rx_d   = '0;
      cnt_d  = '0;
      bits_d = load_bits;
      sclk_d = 1'b0;
    end else if (tick) begin
      if (!sclk_q) begin
        // leading edge: capture the incoming bit
        sclk_d = 1'b1;
        rx_d   = {rx_q[SH_W-2:0], miso};
      end else begin
        // trailing edge: present the next outgoing bit
        sclk_d = 1'b0;
        tx_d   = {tx_q[SH_W-2:0], 1'b0};
        cnt_d  = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q   <= '0;
      rx_q   <= '0;
      cnt_q  <= '0;
      bits_q <= '0;
      sclk_q <= 1'b0;
    end else begin
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      cnt_q  <= cnt_d;
      bits_q <= bits_d;
      sclk_q <= sclk_d;
    end
  end

  assign last_fall = !load && tick && sclk_q && (cnt_q == (bits_q - CNT_W'(1)));
  assign sclk      = sclk_q;
  assign mosi      = tx_q[SH_W-1];
  assign rx_word   = rx_q;

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adcs_pkg::*;
#(
  parameter int unsigned CLK_HZ       = 125_000_000,
  parameter int unsigned MIN_PULSE_NS = 200,
  parameter int unsigned GAP_NS       = 15_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CHAN_W-1:0] chan,
  input  logic              range_sel,
  input  logic              bipolar_sel,
  input  logic              miso,
  output logic              cs_n,
  output logic              sclk,
  output logic              mosi,
  output logic              busy,
  output logic              done,
  output logic [RES_W-1:0]  result,
  output logic              result_signed
);

  localparam longint unsigned CLK_KHZ  = 64'(CLK_HZ) / 64'd1000;
  localparam int HALF_RAW = int'((64'(MIN_PULSE_NS) * CLK_KHZ + 64'd999_999) / 64'd1_000_000);
  localparam int WAIT_RAW = int'((64'(GAP_NS) * CLK_KHZ + 64'd999_999) / 64'd1_000_000);
  localparam int HALF_CYC = (HALF_RAW < 1) ? 1 : HALF_RAW;
  localparam int WAIT_CYC = (WAIT_RAW < 2) ? 2 : WAIT_RAW;
  localparam int CNT_W    = $clog2(SH_W + 1);

  logic rst_ni;

  seq_state_e       state_q, state_d;
  logic             bip_lat_q, bip_lat_d;
  logic             done_q, done_d;
  logic [RES_W-1:0] res_q, res_d;
  logic             sgn_q, sgn_d;

  logic             tick_en, gap_en;
  logic             tick, gap_expire;
  logic             sh_load;
  logic [SH_W-1:0]  sh_data;
  logic [CNT_W-1:0] sh_bits;
  logic             last_fall;
  logic [SH_W-1:0]  rx_word;
  logic             fin;

  adcs_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_ni)
  );

  assign tick_en = (state_q == ST_CMD) || (state_q == ST_READ);
  assign gap_en  = (state_q == ST_GAP);

  adcs_period_cnt #(.PERIOD(HALF_CYC)) u_half_div (
    .clk    (clk),
    .rst_ni (rst_ni),
    .en     (tick_en),
    .expire (tick)
  );

  adcs_period_cnt #(.PERIOD(WAIT_CYC)) u_gap_timer (
    .clk    (clk),
    .rst_ni (rst_ni),
    .en     (gap_en),
    .expire (gap_expire)
  );

  adcs_shift #(.SH_W(SH_W), .CNT_W(CNT_W)) u_shift (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .load      (sh_load),
    .load_data (sh_data),
    .load_bits (sh_bits),
    .tick      (tick),
    .miso      (miso),
    .sclk      (sclk),
    .mosi      (mosi),
    .rx_word   (rx_word),
    .last_fall (last_fall)
  );

  // next-state and phase loading
  always_comb begin
    state_d   = state_q;
    bip_lat_d = bip_lat_q;
    sh_load   = 1'b0;
    sh_data   = '0;
    sh_bits   = CNT_W'(CMD_W);
    fin       = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          sh_load   = 1'b1;
          sh_data   = SH_W'(build_ctrl(chan, range_sel, bipolar_sel)) << (SH_W - CMD_W);
          sh_bits   = CNT_W'(CMD_W);
          bip_lat_d = bipolar_sel;
          state_d   = ST_CMD;
        end
      end
      ST_CMD: begin
        if (last_fall) begin
          state_d = ST_GAP;
        end
      end
      ST_GAP: begin
        if (gap_expire) begin
          sh_load = 1'b1;
          sh_data = '0;
          sh_bits = CNT_W'(RES_W);
          state_d = ST_READ;
        end
      end
      ST_READ: begin
        if (last_fall) begin
          fin     = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // result registers with explicit enable
  always_comb begin
    res_d  = res_q;
    sgn_d  = sgn_q;
    done_d = fin;
    if (fin) begin
      res_d = rx_word[RES_W-1:0];
      sgn_d = bip_lat_q;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bip_lat_q <= 1'b0;
      done_q    <= 1'b0;
      res_q     <= '0;
      sgn_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      bip_lat_q <= bip_lat_d;
      done_q    <= done_d;
      res_q     <= res_d;
      sgn_q     <= sgn_d;
    end
  end

  assign cs_n          = (state_q == ST_IDLE);
  assign busy          = (state_q != ST_IDLE);
  assign done          = done_q;
  assign result        = res_q;
  assign result_signed = sgn_q;

endmodule

// File: rtl/adcs_checker.sv
module adcs_checker #(
  parameter int HALF_CYC = 25,
  parameter int WAIT_CYC = 1875,
  parameter int RES_W    = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             cs_n,
  input logic             sclk,
  input logic             mosi,
  input logic             busy,
  input logic             done,
  input logic [RES_W-1:0] result,
  input logic             result_signed
);

  localparam int RW = $clog2(WAIT_CYC + HALF_CYC + 4) + 1;

  logic          sclk_q;
  logic [RW-1:0] run;
  logic [4:0]    edges;

  // run: samples since sclk last changed; edges: rising edges in this window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      run    <= '0;
      edges  <= '0;
    end else begin
      sclk_q <= sclk;
      if (sclk != sclk_q) begin
        run <= RW'(1);
      end else if (run != {RW{1'b1}}) begin
        run <= run + RW'(1);
      end
      if (cs_n) begin
        edges <= '0;
      end else if (sclk && !sclk_q) begin
        edges <= edges + 5'd1;
      end
    end
  end

  p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (!sclk && !mosi));

  p_high_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> (run >= RW'(HALF_CYC)));

  p_low_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> (run >= RW'(HALF_CYC)));

  p_gap_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sclk) && edges == 5'd8) |-> (run >= RW'(WAIT_CYC + HALF_CYC)));

  p_edge_total_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (edges == 5'd20));

  p_read_mosi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && edges >= 5'd8) |-> !mosi);

  p_cs_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> done);

  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cs_n);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(result) && $stable(result_signed)));

  p_busy_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_busy_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

endmodule

bind adc_conv_seq adcs_checker #(
  .HALF_CYC (HALF_CYC),
  .WAIT_CYC (WAIT_CYC),
  .RES_W    (RES_W)
) u_adcs_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start         (start),
  .cs_n          (cs_n),
  .sclk          (sclk),
  .mosi          (mosi),
  .busy          (busy),
  .done          (done),
  .result        (result),
  .result_signed (result_signed)
);

// File: tb/tb_adc_conv_seq.sv
module tb_adc_conv_seq;

  localparam int CLK_NS   = 8;
  localparam int HALF_EXP = 200 / CLK_NS;     // 25 clocks per sclk phase
  localparam int WAIT_EXP = 15000 / CLK_NS;   // 1875 clocks of gap

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [2:0]  chan;
  logic        range_sel;
  logic        bipolar_sel;
  logic        miso;
  logic        cs_n;
  logic        sclk;
  logic        mosi;
  logic        busy;
  logic        done;
  logic [11:0] result;
  logic        result_signed;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  adc_conv_seq dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .chan          (chan),
    .range_sel     (range_sel),
    .bipolar_sel   (bipolar_sel),
    .miso          (miso),
    .cs_n          (cs_n),
    .sclk          (sclk),
    .mosi          (mosi),
    .busy          (busy),
    .done          (done),
    .result        (result),
    .result_signed (result_signed)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // ---------------- converter model and line monitor ----------------
  logic [11:0] slave_word = 12'h000;
  logic        prev_sclk  = 1'b0;
  logic        prev_cs    = 1'b1;
  logic [7:0]  cmd_sh     = 8'h00;
  int          rises      = 0;
  int          runlen     = 0;
  int          hi_min     = 0, hi_max = 0, lo_min = 0, lo_max = 0;
  int          gap_len    = 0;
  int          windows    = 0;
  bit          mosi_bad   = 1'b0;

  initial miso = 1'b0;

  always @(negedge clk) begin
    if (rst_n && !cs_n && prev_cs) begin
      windows  = windows + 1;
      rises    = 0;
      runlen   = 1;
      hi_min   = 1 << 30; hi_max = 0;
      lo_min   = 1 << 30; lo_max = 0;
      gap_len  = 0;
      mosi_bad = 1'b0;
      miso     = 1'b0;
    end else if (rst_n && !cs_n) begin
      if (sclk && !prev_sclk) begin
        rises = rises + 1;
        if (rises <= 8) cmd_sh = {cmd_sh[6:0], mosi};
        if (rises == 9) begin
          gap_len = runlen;
        end else begin
          if (runlen < lo_min) lo_min = runlen;
          if (runlen > lo_max) lo_max = runlen;
        end
        runlen = 1;
      end else if (!sclk && prev_sclk) begin
        if (runlen < hi_min) hi_min = runlen;
        if (runlen > hi_max) hi_max = runlen;
        runlen = 1;
        if (rises >= 8 && rises <= 19) miso = slave_word[19 - rises];
      end else begin
        runlen = runlen + 1;
      end
      if (rises >= 8 && !(rises == 8 && sclk) && mosi) mosi_bad = 1'b1;
    end
    prev_sclk = sclk;
    prev_cs   = cs_n;
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc >= 200000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: run did not finish, actual=%0d expected<200000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_bad = n_bad + 1;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_ctrl(input logic [2:0] ch, input logic rg, input logic bp);
    return {1'b1, ch, rg, bp, 2'b00};
  endfunction

  task automatic kick(input logic [2:0] ch, input logic rg, input logic bp);
    @(negedge clk);
    chan = ch; range_sel = rg; bipolar_sel = bp; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 10000; i++) begin
      if (done) begin
        seen = 1'b1;
        break;
      end
      @(negedge clk);
    end
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0; chan = 3'd0; range_sel = 1'b0; bipolar_sel = 1'b0;
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1 && sclk == 1'b0 && mosi == 1'b0, "R1", "lines in reset",
        {cs_n, sclk, mosi}, 3'b100);
    chk(busy == 1'b0 && done == 1'b0, "R1", "busy/done in reset", {busy, done}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(cs_n == 1'b1 && sclk == 1'b0 && mosi == 1'b0 && !busy && !done, "R1",
        "idle after reset", {cs_n, sclk, mosi, busy, done}, 5'b10000);
  endtask

  task automatic t_conv(input logic [2:0] ch, input logic rg, input logic bp,
                        input logic [11:0] word);
    bit seen;
    int w0;
    slave_word = word;
    w0 = windows;
    kick(ch, rg, bp);
    chk(busy == 1'b1, "R8", "busy after start", busy, 1);
    chk(cs_n == 1'b0, "R6", "cs_n after start", cs_n, 0);
    wait_done(seen);
    chk(seen, "R7", "done seen", seen, 1);
    chk(result == word, "R5", "result word", result, word);
    chk(result_signed == bp, "R10", "signed flag", result_signed, bp);
    chk(cs_n == 1'b1, "R6", "cs_n at done", cs_n, 1);
    chk(busy == 1'b0, "R8", "busy at done", busy, 0);
    chk(cmd_sh == exp_ctrl(ch, rg, bp), "R2", "control word", cmd_sh, exp_ctrl(ch, rg, bp));
    chk(rises == 20, "R4", "rising edges", rises, 20);
    chk(hi_min == HALF_EXP && hi_max == HALF_EXP, "R3", "high width", hi_max, HALF_EXP);
    chk(lo_min == HALF_EXP && lo_max == HALF_EXP, "R3", "low width", lo_max, HALF_EXP);
    chk(gap_len == WAIT_EXP + HALF_EXP, "R4", "gap length", gap_len, WAIT_EXP + HALF_EXP);
    chk(mosi_bad == 1'b0, "R5", "mosi low while reading", mosi_bad, 0);
    chk(windows == w0 + 1, "R6", "single cs window", windows - w0, 1);
    @(negedge clk);
    chk(done == 1'b0, "R7", "done one cycle", done, 0);
  endtask

  task automatic t_busy_ignore();
    bit seen;
    int w0;
    slave_word = 12'h3C7;
    w0 = windows;
    kick(3'd3, 1'b0, 1'b1);
    repeat (300) @(negedge clk);
    chan = 3'd6; range_sel = 1'b1; bipolar_sel = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (800) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(seen);
    chk(seen, "R9", "done seen", seen, 1);
    chk(cmd_sh == exp_ctrl(3'd3, 1'b0, 1'b1), "R9", "control word kept", cmd_sh,
        exp_ctrl(3'd3, 1'b0, 1'b1));
    chk(rises == 20, "R9", "no restart edges", rises, 20);
    chk(result == 12'h3C7, "R9", "result", result, 12'h3C7);
    chk(result_signed == 1'b1, "R10", "latched polarity", result_signed, 1);
    repeat (60) @(negedge clk);
    chk(cs_n == 1'b1 && busy == 1'b0, "R9", "no queued start", {cs_n, busy}, 2'b10);
    chk(windows == w0 + 1, "R9", "cs windows", windows - w0, 1);
  endtask

  task automatic t_hold();
    logic [11:0] r0;
    logic        s0;
    r0 = result;
    s0 = result_signed;
    chan = 3'd1; range_sel = 1'b1; bipolar_sel = ~s0;
    repeat (200) @(negedge clk);
    chk(result == r0 && result_signed == s0, "R7", "result held", result, r0);
    chk(cs_n == 1'b1 && sclk == 1'b0 && mosi == 1'b0 && !busy, "R1", "idle lines",
        {cs_n, sclk, mosi, busy}, 4'b1000);
  endtask

  initial begin
    t_reset();
    t_conv(3'd5, 1'b1, 1'b0, 12'hA5C);
    t_conv(3'd0, 1'b0, 1'b0, 12'h000);
    t_conv(3'd7, 1'b1, 1'b1, 12'hFFF);
    t_conv(3'd2, 1'b0, 1'b1, 12'h800);
    t_hold();
    t_busy_ignore();
    t_conv(3'd4, 1'b1, 1'b0, 12'h7FF);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule